// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Chain

This block compares two unsigned words of a configurable width and reports which one is larger, or that they match. It is built from fixed-width comparison slices joined in a chain. Each slice scans its own group of operand bits from the top bit downward, and the first unequal bit settles its verdict. A slice whose bits all match does not decide anything itself. It forwards the verdict it received from the slice below, which covers the less significant bits.

The chain's entry verdict comes in on three cascade input ports. With those ports set to "equal only", the block is a plain comparator. Wiring them to the outputs of another comparator extends the comparison to wider words. If the operand width does not divide evenly into slices, the unused upper bits of the top slice are filled with zeros on both sides. A parameter selects whether the three verdict outputs are registered, for timing closure, or combinational.

Top module: `magcmp_chain`

## Requirements
- R1: Whenever exactly one cascade input is high, exactly one of gt_o, eq_o and lt_o is high.
- R2: When a_i is greater than b_i as unsigned numbers, the output is gt_o=1, eq_o=0, lt_o=0, whatever the cascade inputs carry.
- R3: When a_i is less than b_i as unsigned numbers, the output is gt_o=0, eq_o=0, lt_o=1, whatever the cascade inputs carry.
- R4: The most significant differing bit decides the result, even when a lower slice holds an opposite difference. For example, a_i=100000 against b_i=011111 gives gt_o.
- R5: When a_i equals b_i, the outputs copy casc_gt_i, casc_eq_i and casc_lt_i bit for bit. This also holds for the illegal codes with no bit or several bits set.
- R6: With the cascade inputs held at casc_gt_i=0, casc_eq_i=1, casc_lt_i=0, equal operands give eq_o alone.
- R7: When DATA_W is not a multiple of the slice width, the top bits of the operands still take part in full. For example, with a_i holding only its MSB and b_i=0, the result is gt_o.
- R8: With OUT_REG=1, the outputs change one clock after the operands change. While rst is high, the outputs hold gt_o=0, eq_o=1, lt_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | DATA_W | First unsigned operand |
| b_i | input | DATA_W | Second unsigned operand |
| casc_gt_i | input | 1 | Incoming verdict from less significant logic: A greater |
| casc_eq_i | input | 1 | Incoming verdict: equal |
| casc_lt_i | input | 1 | Incoming verdict: A less |
| gt_o | output | 1 | a_i is greater than b_i |
| eq_o | output | 1 | a_i equals b_i (with a tie at the cascade inputs) |
| lt_o | output | 1 | a_i is less than b_i |

## Verification
A local decision in an upper slice can arrive in the same cycle as an opposite decision in a lower slice, or as an opposite verdict on the cascade inputs. Only the most significant disagreement may reach the outputs. The sweep uses a small configuration with two slices and a padded top slice. It pairs every operand combination with all eight cascade codes, so each such collision occurs many times. Each result is judged against the arithmetic relation of the two operands, with the cascade code taking over only on an exact match.

// File: rtl/magcmp_pkg.sv
`timescale 1ns/1ps
package magcmp_pkg;

    // Three-way verdict carried between slices and to the outputs.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    localparam rel_t REL_TIE   = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
    localparam rel_t REL_ABOVE = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
    localparam rel_t REL_BELOW = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};

    // Number of slices needed to cover a word.
    function automatic int slice_count(input int data_w, input int slice_w);
        return (data_w + slice_w - 1) / slice_w;
    endfunction

    // Verdict of a single bit pair when it differs.
    function automatic rel_t bit_verdict(input logic a, input logic b);
        rel_t r;
        r.gt = a & ~b;
        r.eq = ~(a ^ b);
        r.lt = ~a & b;
        return r;
    endfunction

endpackage

// File: rtl/magcmp_slice.sv
`timescale 1ns/1ps
module magcmp_slice
    import magcmp_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  rel_t               below_i,
    output rel_t               verdict_o
);

    rel_t [SLICE_W-1:0] bit_rel;

    // Per-bit greater / equal / less terms.
    for (genvar k = 0; k < SLICE_W; k++) begin : g_bit
        assign bit_rel[k] = bit_verdict(a_i[k], b_i[k]);
    end

    // Scan from the top bit; the first unequal position settles the slice.
    // With every bit equal the verdict from below is forwarded untouched.
    always_comb begin
        logic settled;
        settled   = 1'b0;
        verdict_o = below_i;
        for (int k = SLICE_W - 1; k >= 0; k--) begin
            if (!settled && !bit_rel[k].eq) begin
                verdict_o.gt = bit_rel[k].gt;
                verdict_o.eq = 1'b0;
                verdict_o.lt = bit_rel[k].lt;
                settled      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/magcmp_ladder.sv
`timescale 1ns/1ps
module magcmp_ladder
    import magcmp_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int SLICE_W = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  rel_t              entry_i,
    output rel_t              result_o
);

    localparam int N_SLICE = slice_count(DATA_W, SLICE_W);
    localparam int PAD_W   = N_SLICE * SLICE_W;

    logic [PAD_W-1:0] a_pad;
    logic [PAD_W-1:0] b_pad;

    // Upper bits of the top slice are zero on both sides.
    always_comb begin
        a_pad             = '0;
        b_pad             = '0;
        a_pad[DATA_W-1:0] = a_i;
        b_pad[DATA_W-1:0] = b_i;
    end

    rel_t link [N_SLICE+1];

    assign link[0] = entry_i;

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        magcmp_slice #(
            .SLICE_W (SLICE_W)
        ) slice_i (
            .a_i       (a_pad[s*SLICE_W +: SLICE_W]),
            .b_i       (b_pad[s*SLICE_W +: SLICE_W]),
            .below_i   (link[s]),
            .verdict_o (link[s+1])
        );
    end

    assign result_o = link[N_SLICE];

endmodule

// File: rtl/magcmp_out_stage.sv
`timescale 1ns/1ps
module magcmp_out_stage
    import magcmp_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  rel_t rel_i,
    output rel_t rel_o
);

    if (OUT_REG) begin : g_reg
        rel_t rel_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                rel_q <= REL_TIE;
            end else begin
                rel_q <= rel_i;
            end
        end
        assign rel_o = rel_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign rel_o      = rel_i;
    end

endmodule

// File: rtl/magcmp_chain.sv
`timescale 1ns/1ps
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int SLICE_W = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              casc_gt_i,
    input  logic              casc_eq_i,
    input  logic              casc_lt_i,
    output logic              gt_o,
    output logic              eq_o,
    output logic              lt_o
);

    rel_t entry_w;
    rel_t comb_w;
    rel_t final_w;

    assign entry_w.gt = casc_gt_i;
    assign entry_w.eq = casc_eq_i;
    assign entry_w.lt = casc_lt_i;

    magcmp_ladder #(
        .DATA_W  (DATA_W),
        .SLICE_W (SLICE_W)
    ) ladder_i (
        .a_i      (a_i),
        .b_i      (b_i),
        .entry_i  (entry_w),
        .result_o (comb_w)
    );

    magcmp_out_stage #(
        .OUT_REG (OUT_REG)
    ) out_i (
        .clk   (clk),
        .rst   (rst),
        .rel_i (comb_w),
        .rel_o (final_w)
    );

    assign gt_o = final_w.gt;
    assign eq_o = final_w.eq;
    assign lt_o = final_w.lt;

endmodule

// File: rtl/magcmp_chain_chk.sv
`timescale 1ns/1ps
module magcmp_chain_chk #(
    parameter int DATA_W  = 10,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              casc_gt_i,
    input logic              casc_eq_i,
    input logic              casc_lt_i,
    input logic              gt_o,
    input logic              eq_o,
    input logic              lt_o
);

    logic       primed_q;
    logic [2:0] rel_w;
    logic [2:0] cin_w;

    assign rel_w = {gt_o, eq_o, lt_o};
    assign cin_w = {casc_gt_i, casc_eq_i, casc_lt_i};

    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end

    if (OUT_REG) begin : g_reg
        AST_GT_ABOVE: assert property (@(posedge clk) disable iff (rst)
            (primed_q && $past(a_i > b_i)) |-> (rel_w == 3'b100)); // R2
        AST_LT_BELOW: assert property (@(posedge clk) disable iff (rst)
            (primed_q && $past(a_i < b_i)) |-> (rel_w == 3'b001)); // R3
        AST_TIE_PASSES: assert property (@(posedge clk) disable iff (rst)
            (primed_q && $past(a_i == b_i)) |-> (rel_w == $past(cin_w))); // R5
        AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
            (primed_q && ($countones($past(cin_w)) == 1)) |-> ($countones(rel_w) == 1)); // R1
        AST_RESET_TIE: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (rel_w == 3'b010)); // R8
    end else begin : g_comb
        AST_GT_ABOVE: assert property (@(posedge clk) disable iff (rst)
            (a_i > b_i) |-> (rel_w == 3'b100)); // R2
        AST_LT_BELOW: assert property (@(posedge clk) disable iff (rst)
            (a_i < b_i) |-> (rel_w == 3'b001)); // R3
        AST_TIE_PASSES: assert property (@(posedge clk) disable iff (rst)
            (a_i == b_i) |-> (rel_w == cin_w)); // R5
        AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
            ($countones(cin_w) == 1) |-> ($countones(rel_w) == 1)); // R1
    end

endmodule

bind magcmp_chain magcmp_chain_chk #(
    .DATA_W  (DATA_W),
    .OUT_REG (OUT_REG)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .a_i       (a_i),
    .b_i       (b_i),
    .casc_gt_i (casc_gt_i),
    .casc_eq_i (casc_eq_i),
    .casc_lt_i (casc_lt_i),
    .gt_o      (gt_o),
    .eq_o      (eq_o),
    .lt_o      (lt_o)
);

// File: tb/magcmp_chain_tb_top.sv
`timescale 1ns/1ps
module magcmp_chain_tb_top;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [2:0]   cin = 3'b010;
    logic         gt, eq, lt;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    magcmp_chain #(
        .DATA_W  (W),
        .SLICE_W (4),
        .OUT_REG (1'b1)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .a_i       (a),
        .b_i       (b),
        .casc_gt_i (cin[2]),
        .casc_eq_i (cin[1]),
        .casc_lt_i (cin[0]),
        .gt_o      (gt),
        .eq_o      (eq),
        .lt_o      (lt)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%0d b=%0d cin=%b actual=%b expected=%b", tag, a, b, cin, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the capturing rising edge.
    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [2:0] cv);
        @(negedge clk);
        a   = av;
        b   = bv;
        cin = cv;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [2:0] model(input int av, input int bv, input logic [2:0] cv);
        if (av > bv) return 3'b100;
        if (av < bv) return 3'b001;
        return cv;
    endfunction

    initial begin
        // R8: reset holds the tie code even with unequal operands present.
        a = 6'd7; b = 6'd1; cin = 3'b100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset code", {gt, eq, lt}, 3'b010);
        rst = 1'b0;

        // R8: one clock of latency.
        apply(6'd9, 6'd9, 3'b010);
        check("R6 plain tie", {gt, eq, lt}, 3'b010);
        @(negedge clk);
        a = 6'd40; b = 6'd3;
        #1;
        check("R8 before edge", {gt, eq, lt}, 3'b010);
        @(posedge clk);
        #1;
        check("R8 after edge", {gt, eq, lt}, 3'b100);

        // R4: top difference beats opposite lower differences.
        apply(6'b100000, 6'b011111, 3'b001);
        check("R4 msb wins", {gt, eq, lt}, 3'b100);
        apply(6'b010000, 6'b001111, 3'b001);
        check("R4 slice1 wins", {gt, eq, lt}, 3'b100);
        apply(6'b000110, 6'b000111, 3'b100);
        check("R4 lsb only", {gt, eq, lt}, 3'b001);

        // R7: padded top slice bits.
        apply(6'b100000, 6'b000000, 3'b010);
        check("R7 top bit", {gt, eq, lt}, 3'b100);
        apply(6'b000000, 6'b010000, 3'b010);
        check("R7 second bit", {gt, eq, lt}, 3'b001);

        // R5: illegal codes pass through on a tie.
        apply(6'd21, 6'd21, 3'b000);
        check("R5 empty code", {gt, eq, lt}, 3'b000);
        apply(6'd63, 6'd63, 3'b111);
        check("R5 full code", {gt, eq, lt}, 3'b111);

        // Full sweep over all operands and all cascade codes (R1 R2 R3 R5 R6).
        for (int c = 0; c < 8; c++) begin
            for (int ai = 0; ai < (1 << W); ai++) begin
                for (int bi = 0; bi < (1 << W); bi++) begin
                    logic [2:0] exp;
                    exp = model(ai, bi, 3'(c));
                    apply(W'(ai), W'(bi), 3'(c));
                    if (ai > bi)       check("R2 greater", {gt, eq, lt}, exp);
                    else if (ai < bi)  check("R3 less", {gt, eq, lt}, exp);
                    else if (c == 2)   check("R6 tie entry", {gt, eq, lt}, exp);
                    else               check("R5 pass code", {gt, eq, lt}, exp);
                    if (c == 1 || c == 2 || c == 4) begin
                        checks++;
                        if ($countones({gt, eq, lt}) != 1) begin
                            failures++;
                            $display("FAIL R1 one-hot actual=%b expected=one bit", {gt, eq, lt});
                        end
                    end
                end
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule